// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block is a full-duplex serial channel that exchanges 8-bit frames with a peer over three wires: a serial clock it generates itself, a transmit data line and a receive data line. Each frame sends the least significant bit first. The block changes transmit data on the falling edge of the serial clock and samples receive data on the rising edge. The serial clock toggles only while a frame is in flight and rests high otherwise. A frame starts when software or a DMA engine has left a byte pending in the transmit data register. The frame moves that byte into a shifter and, at the same time, captures eight bits from the peer.

A host processor reaches the block through a small register port with four locations. Status flags report three conditions: the transmit register is free, a received byte is waiting, and an overrun has occurred. Software clears a flag with a two-step handshake. Two DMA acknowledge strobes clear the transmit-empty and receive-full flags without any software step. Three interrupt request lines are driven from the flags and two enable bits. If a byte arrives before the previous one has been collected, the block raises the overrun flag and halts all traffic until that flag is cleared.

The engine state machine has four states. ENG_IDLE rests the clock high. ENG_LOW is the clock-low half-bit, in which transmit data is presented. ENG_HIGH is the clock-high half-bit. ENG_END is a one-cycle frame delivery step. The transitions are: IDLE->LOW when data is pending and no overrun is flagged; LOW->HIGH when a half period has elapsed, with receive data sampled on this step; HIGH->LOW after the half period while bits remain, with the shifter advancing; HIGH->END after the eighth bit; END->IDLE always.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the status reads 0x01 (transmit empty only), the control register reads 0x00, the serial clock and transmit line are high, and all three interrupt requests are low.
- R2: A frame drives the 8 bits of the transmit byte onto the transmit line, LSB first, changing them after the falling edge of the serial clock. Each frame has exactly 8 falling edges. With nothing pending, the serial clock stays high.
- R3: The receive line is sampled on each rising edge of the serial clock, LSB first. At frame end, if receive-full is 0, the byte goes to the receive data register and receive-full becomes 1.
- R4: A frame starts only while transmit-empty is 0 and overrun is 0. At the start the pending byte moves into the shifter and transmit-empty returns to 1. A byte made pending before the current frame ends is sent as the next frame, with no extra host action.
- R5: A frame that ends while receive-full is 1 sets overrun, leaves receive-full at 1 and leaves the receive data register unchanged.
- R6: While overrun is 1, no frame starts, even with a byte pending. Traffic resumes once overrun is cleared.
- R7: A flag is cleared by reading the status register while the flag is 1 and then writing 0 to its bit. Writing 1 to a flag bit has no effect. Writing 0 without a preceding read that saw the flag at 1 has no effect. Any status write consumes the read.
- R8: irq_tx = transmit-empty AND tx enable; irq_rx = receive-full AND rx enable; irq_err = overrun AND rx enable. The rx enable serves both receive requests.
- R9: A dma_tx_ack pulse loads dma_tx_data into the transmit data register and clears transmit-empty, which starts a frame.
- R10: A dma_rx_ack pulse clears receive-full. The received byte is visible on rx_data_o.
- R11: Register map: address 0 is control (bit0 tx enable, bit1 rx enable); address 1 is status (bit0 transmit-empty, bit1 receive-full, bit2 overrun, other bits 0); address 2 is transmit data (write); address 3 is receive data (read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms flag clearing) |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| dma_tx_ack | input | 1 | DMA transmit transfer strobe |
| dma_tx_data | input | 8 | Byte written by the DMA transfer |
| dma_rx_ack | input | 1 | DMA receive transfer strobe |
| rx_data_o | output | 8 | Receive data register contents |
| sclk_o | output | 1 | Serial clock, idle high |
| txd_o | output | 1 | Serial transmit data |
| rxd_i | input | 1 | Serial receive data |
| irq_tx | output | 1 | Transmit-empty request |
| irq_rx | output | 1 | Receive-full request |
| irq_err | output | 1 | Receive-error request |

## Verification
The hardest state to reach is the overrun lockout with a byte already pending. Reaching it takes two complete frames with the first byte left uncollected, then a third byte made pending while overrun is set. The clearing order then matters: receive-full must be cleared before overrun, or the released frame overruns again. A bench-side peer model answers every serial clock edge, which produces both frames. The bench then holds a pending byte through a long idle window, counts the serial clock edges to show that nothing moves, and checks that the frame released by the clear carries the expected byte in both directions. Back-to-back frames are covered by writing the next byte during a frame, as soon as transmit-empty returns.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_LOW  = 2'd1,
        ENG_HIGH = 2'd2,
        ENG_END  = 2'd3
    } eng_state_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_TXD  = 2'd2;
    localparam logic [1:0] ADDR_RXD  = 2'd3;

    localparam int FLG_TXE  = 0;
    localparam int FLG_RXF  = 1;
    localparam int FLG_OVR  = 2;
    localparam int NUM_FLG  = 3;

    localparam int CTL_TXIE = 0;
    localparam int CTL_RXIE = 1;
endpackage

// File: rtl/ssp_shift_engine.sv
module ssp_shift_engine
    import ssp_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              rxd,
    output logic              frame_start,
    output logic              frame_done,
    output logic [DATA_W-1:0] rx_word,
    output logic              sclk,
    output logic              txd
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    eng_state_t        state_q, state_d;
    logic [DIV_W-1:0]  div_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] tx_sh_q, rx_sh_q;
    logic              half_end, last_bit;

    assign half_end = (div_q == DIV_LAST);
    assign last_bit = (bit_q == BIT_LAST);
    assign rx_word  = rx_sh_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENG_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE: if (go)       state_d = ENG_LOW;
            ENG_LOW:  if (half_end) state_d = ENG_HIGH;
            ENG_HIGH: if (half_end) state_d = last_bit ? ENG_END : ENG_LOW;
            ENG_END:                state_d = ENG_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        sclk        = 1'b1;
        txd         = 1'b1;
        frame_start = 1'b0;
        frame_done  = 1'b0;
        unique case (state_q)
            ENG_IDLE: frame_start = go;
            ENG_LOW: begin
                sclk = 1'b0;
                txd  = tx_sh_q[0];
            end
            ENG_HIGH: txd = tx_sh_q[0];
            ENG_END:  frame_done = 1'b1;
        endcase
    end

    // datapath: half-bit timer, bit counter, shifters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= '0;
            bit_q   <= '0;
            tx_sh_q <= '0;
            rx_sh_q <= '0;
        end else begin
            if ((state_q == ENG_LOW || state_q == ENG_HIGH) && !half_end)
                div_q <= div_q + 1'b1;
            else
                div_q <= '0;

            if (state_q == ENG_IDLE && go) begin
                tx_sh_q <= tx_word;
                bit_q   <= '0;
            end
            if (state_q == ENG_LOW && half_end)
                rx_sh_q <= {rxd, rx_sh_q[DATA_W-1:1]};
            if (state_q == ENG_HIGH && half_end && !last_bit) begin
                tx_sh_q <= {1'b1, tx_sh_q[DATA_W-1:1]};
                bit_q   <= bit_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ssp_host_regs.sv
module ssp_host_regs
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dma_tx_ack,
    input  logic [DATA_W-1:0] dma_tx_data,
    input  logic              dma_rx_ack,
    input  logic              frame_start,
    input  logic              frame_done,
    input  logic [DATA_W-1:0] rx_word,
    output logic [DATA_W-1:0] tx_word,
    output logic [DATA_W-1:0] rx_buf,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              overrun,
    output logic              tx_ie,
    output logic              rx_ie
);
    logic [NUM_FLG-1:0] flags, armed, sw_clr;
    logic stat_wr, stat_rd, ctrl_wr, txd_wr;

    assign stat_wr = bus_wr && (bus_addr == ADDR_STAT);
    assign stat_rd = bus_rd && (bus_addr == ADDR_STAT);
    assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
    assign txd_wr  = bus_wr && (bus_addr == ADDR_TXD);

    assign flags[FLG_TXE] = tx_empty;
    assign flags[FLG_RXF] = rx_full;
    assign flags[FLG_OVR] = overrun;

    // a zero written to an armed flag bit clears it
    for (genvar g = 0; g < NUM_FLG; g++) begin : g_clr
        assign sw_clr[g] = stat_wr && !bus_wdata[g] && armed[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       armed <= '0;
        else if (stat_wr) armed <= '0;
        else if (stat_rd) armed <= armed | flags;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_empty <= 1'b1;
            rx_full  <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            if (frame_start)              tx_empty <= 1'b1;
            else if (dma_tx_ack)          tx_empty <= 1'b0;
            else if (sw_clr[FLG_TXE])     tx_empty <= 1'b0;

            if (frame_done && !rx_full)   rx_full <= 1'b1;
            else if (dma_rx_ack)          rx_full <= 1'b0;
            else if (sw_clr[FLG_RXF])     rx_full <= 1'b0;

            if (frame_done && rx_full)    overrun <= 1'b1;
            else if (sw_clr[FLG_OVR])     overrun <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_ie   <= 1'b0;
            rx_ie   <= 1'b0;
            tx_word <= '0;
            rx_buf  <= '0;
        end else begin
            if (ctrl_wr) begin
                tx_ie <= bus_wdata[CTL_TXIE];
                rx_ie <= bus_wdata[CTL_RXIE];
            end
            if (dma_tx_ack)  tx_word <= dma_tx_data;
            else if (txd_wr) tx_word <= bus_wdata;
            if (frame_done && !rx_full) rx_buf <= rx_word;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTRL: begin
                bus_rdata[CTL_TXIE] = tx_ie;
                bus_rdata[CTL_RXIE] = rx_ie;
            end
            ADDR_STAT: bus_rdata[NUM_FLG-1:0] = flags;
            ADDR_TXD:  bus_rdata = '0;
            ADDR_RXD:  bus_rdata = rx_buf;
        endcase
    end
endmodule

// File: rtl/ssp_irq_gen.sv
module ssp_irq_gen (
    input  logic tx_empty,
    input  logic rx_full,
    input  logic overrun,
    input  logic tx_ie,
    input  logic rx_ie,
    output logic irq_tx,
    output logic irq_rx,
    output logic irq_err
);
    assign irq_tx  = tx_empty & tx_ie;
    assign irq_rx  = rx_full & rx_ie;
    assign irq_err = overrun & rx_ie;   // shares the receive enable
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dma_tx_ack,
    input  logic [DATA_W-1:0] dma_tx_data,
    input  logic              dma_rx_ack,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              sclk_o,
    output logic              txd_o,
    input  logic              rxd_i,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_err
);
    logic              tx_empty_w, rx_full_w, overrun_w, tx_ie_w, rx_ie_w;
    logic              start_w, done_w, go_w;
    logic [DATA_W-1:0] tx_word_w, rx_word_w;

    // a frame needs pending data and no outstanding overrun
    assign go_w = !tx_empty_w && !overrun_w;

    ssp_shift_engine #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) u_engine (
        .clk(clk), .rst_n(rst_n), .go(go_w), .tx_word(tx_word_w), .rxd(rxd_i),
        .frame_start(start_w), .frame_done(done_w), .rx_word(rx_word_w),
        .sclk(sclk_o), .txd(txd_o)
    );

    ssp_host_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dma_tx_ack(dma_tx_ack),
        .dma_tx_data(dma_tx_data), .dma_rx_ack(dma_rx_ack), .frame_start(start_w),
        .frame_done(done_w), .rx_word(rx_word_w), .tx_word(tx_word_w), .rx_buf(rx_data_o),
        .tx_empty(tx_empty_w), .rx_full(rx_full_w), .overrun(overrun_w),
        .tx_ie(tx_ie_w), .rx_ie(rx_ie_w)
    );

    ssp_irq_gen u_irq (
        .tx_empty(tx_empty_w), .rx_full(rx_full_w), .overrun(overrun_w),
        .tx_ie(tx_ie_w), .rx_ie(rx_ie_w),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
    );
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk,
    input logic              tx_empty,
    input logic              rx_full,
    input logic              overrun,
    input logic [DATA_W-1:0] rx_buf,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic              dma_tx_ack
);
    // R6: no serial clock activity while overrun is flagged
    p_lockout_r6: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> sclk);

    // R5: a held byte is never overwritten
    p_rxbuf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && $past(rx_full)) |-> $stable(rx_buf));

    // R5: overrun only arises while a byte is still waiting
    p_ovr_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> rx_full);

    // R4: transmit-empty returns exactly as the first clock-low half begins
    p_txe_on_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> !sclk);

    // R7/R9: transmit-empty falls only through a status write or a DMA strobe
    p_txe_clear_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_empty) |-> $past(dma_tx_ack || (bus_wr && bus_addr == 2'd1)));
endmodule

bind sync_serial_port ssp_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk_o), .tx_empty(tx_empty_w),
    .rx_full(rx_full_w), .overrun(overrun_w), .rx_buf(rx_data_o),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .dma_tx_ack(dma_tx_ack)
);

// File: tb/sync_serial_port_bench.sv
module sync_serial_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_TXD = 2'd2, A_RXD = 2'd3;
    localparam int NVEC = 6;
    // {byte sent by block, byte sent by peer}
    localparam logic [15:0] VEC [NVEC] = '{16'hA53C, 16'h00FF, 16'hFF00,
                                           16'h0180, 16'h8001, 16'h5AC3};

    logic       clk = 1'b0, rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata, dma_tx_data = '0, rx_data_o;
    logic       dma_tx_ack = 1'b0, dma_rx_ack = 1'b0;
    logic       sclk_o, txd_o, rxd_i = 1'b1, irq_tx, irq_rx, irq_err;

    int n_chk = 0, n_err = 0, falls = 0, slv_idx = 0;
    bit finished = 1'b0;
    logic [7:0] slv_out = '0, slv_in = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_serial_port u_sync_serial_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dma_tx_ack(dma_tx_ack),
        .dma_tx_data(dma_tx_data), .dma_rx_ack(dma_rx_ack), .rx_data_o(rx_data_o),
        .sclk_o(sclk_o), .txd_o(txd_o), .rxd_i(rxd_i),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
    );

    // peer model: drive on falling edge, capture on rising edge
    always @(negedge sclk_o) if (rst_n) begin
        rxd_i <= slv_out[slv_idx];
        falls <= falls + 1;
    end
    always @(posedge sclk_o) if (rst_n) begin
        slv_in[slv_idx] <= txd_o;
        slv_idx <= (slv_idx + 1) % 8;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // read status then write 0 to one flag bit, 1 elsewhere
    task automatic clear_flag(input int b);
        logic [7:0] s;
        bus_read(A_STAT, s);
        bus_write(A_STAT, 8'h07 & ~(8'h01 << b));
    endtask

    task automatic wait_flag(input int b, output bit ok);
        logic [7:0] s;
        ok = 1'b0;
        for (int k = 0; k < 200 && !ok; k++) begin
            bus_read(A_STAT, s);
            ok = s[b];
        end
    endtask

    task automatic dma_pulse(input bit tx, input logic [7:0] d);
        @(negedge clk);
        if (tx) begin dma_tx_ack = 1'b1; dma_tx_data = d; end
        else dma_rx_ack = 1'b1;
        @(negedge clk);
        dma_tx_ack = 1'b0; dma_rx_ack = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin : main
        logic [7:0] s;
        bit ok;
        int f0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 / R11 reset state through the register map
        bus_read(A_STAT, s);  chk(s == 8'h01, "R1 R11 status after reset", s, 1);
        bus_read(A_CTRL, s);  chk(s == 8'h00, "R1 R11 control after reset", s, 0);
        chk({sclk_o, txd_o, irq_tx, irq_rx, irq_err} == 5'b11000, "R1 idle lines",
            {sclk_o, txd_o, irq_tx, irq_rx, irq_err}, 5'b11000);

        // R2 serial clock idle with nothing pending
        f0 = falls;
        repeat (40) @(negedge clk);
        chk(falls == f0, "R2 clock idle when empty", falls - f0, 0);

        // R7 write 0 without arming read, and write 1, have no effect
        bus_write(A_STAT, 8'hFF);
        bus_write(A_STAT, 8'h00);
        bus_read(A_STAT, s);  chk(s == 8'h01, "R7 unarmed clear ignored", s, 1);

        // R8 transmit request follows its enable
        bus_write(A_CTRL, 8'h01);
        #1 chk(irq_tx == 1'b1, "R8 irq_tx with enable", irq_tx, 1);
        bus_write(A_CTRL, 8'h00);
        #1 chk(irq_tx == 1'b0, "R8 irq_tx disabled", irq_tx, 0);

        // R2 / R3 vector table of full-duplex frames
        for (int i = 0; i < NVEC; i++) begin
            slv_out = VEC[i][7:0];
            f0 = falls;
            bus_write(A_TXD, VEC[i][15:8]);
            clear_flag(0);
            wait_flag(1, ok);
            chk(ok, "R3 receive-full set", ok, 1);
            bus_read(A_RXD, s);
            chk(s == VEC[i][7:0], "R3 received byte", s, VEC[i][7:0]);
            chk(slv_in == VEC[i][15:8], "R2 sent byte LSB first", slv_in, VEC[i][15:8]);
            chk(falls - f0 == 8, "R2 eight clock falls", falls - f0, 8);
            clear_flag(1);
            bus_read(A_STAT, s);
            chk(s == 8'h01, "R7 receive-full cleared", s, 1);
        end

        // R4 back-to-back frames
        slv_out = 8'h11;
        f0 = falls;
        bus_write(A_TXD, 8'h96);
        clear_flag(0);
        wait_flag(0, ok);
        bus_write(A_TXD, 8'h69);
        clear_flag(0);
        wait_flag(1, ok);
        bus_read(A_RXD, s);
        chk(s == 8'h11, "R4 first frame data", s, 8'h11);
        clear_flag(1);
        wait_flag(1, ok);
        chk(slv_in == 8'h69, "R4 second frame byte", slv_in, 8'h69);
        chk(falls - f0 == 16, "R4 two frames clocked", falls - f0, 16);
        bus_read(A_STAT, s);
        chk(s == 8'h03, "R4 status after chain", s, 3);
        clear_flag(1);

        // R5 overrun with receive interrupts enabled
        bus_write(A_CTRL, 8'h02);
        slv_out = 8'h3C;
        bus_write(A_TXD, 8'h01);
        clear_flag(0);
        wait_flag(1, ok);
        #1 chk({irq_rx, irq_err} == 2'b10, "R8 irq_rx raised", {irq_rx, irq_err}, 2);
        slv_out = 8'hC3;
        bus_write(A_TXD, 8'h02);
        clear_flag(0);
        wait_flag(2, ok);
        chk(ok, "R5 overrun set", ok, 1);
        bus_read(A_STAT, s);
        chk(s == 8'h07, "R5 status at overrun", s, 7);
        bus_read(A_RXD, s);
        chk(s == 8'h3C, "R5 receive register kept", s, 8'h3C);
        #1 chk(irq_err == 1'b1, "R8 irq_err raised", irq_err, 1);

        // R6 lockout with a pending byte
        f0 = falls;
        bus_write(A_TXD, 8'h77);
        clear_flag(0);
        repeat (60) @(negedge clk);
        chk(falls == f0, "R6 no frame while overrun", falls - f0, 0);
        bus_read(A_STAT, s);
        chk(s == 8'h06, "R6 byte still pending", s, 6);

        // R7 writing ones has no effect
        bus_read(A_STAT, s);
        bus_write(A_STAT, 8'h07);
        bus_read(A_STAT, s);
        chk(s == 8'h06, "R7 write one ignored", s, 6);

        // release: receive-full first, then overrun
        slv_out = 8'h5A;
        clear_flag(1);
        #1 chk({irq_rx, irq_err} == 2'b01, "R8 only irq_err left", {irq_rx, irq_err}, 1);
        clear_flag(2);
        wait_flag(1, ok);
        chk(ok, "R6 frame resumes", ok, 1);
        bus_read(A_RXD, s);
        chk(s == 8'h5A, "R6 resumed frame data", s, 8'h5A);
        chk(slv_in == 8'h77, "R6 resumed frame byte", slv_in, 8'h77);

        // R10 DMA receive acknowledge
        dma_pulse(1'b0, 8'h00);
        bus_read(A_STAT, s);
        chk(s == 8'h01, "R10 dma clears receive-full", s, 1);

        // R9 DMA transmit acknowledge
        slv_out = 8'hE7;
        dma_pulse(1'b1, 8'h4B);
        wait_flag(1, ok);
        chk(slv_in == 8'h4B, "R9 dma byte sent", slv_in, 8'h4B);
        chk(rx_data_o == 8'hE7, "R10 rx_data_o byte", rx_data_o, 8'hE7);
        dma_pulse(1'b0, 8'h00);
        bus_read(A_STAT, s);
        chk(s == 8'h01, "R10 dma clear after frame", s, 1);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end
endmodule